// File: doc/BRIEF.md
# Serial fuse-bit programming sequencer

This block runs one programming or verify cycle on an 11-bit non-volatile configuration store through three wires: a select/data line, a serial clock and a program-voltage enable. The store also drives a verify level, which arrives here already digitized. A host gives an operation (program or read), a target bit index and a one-cycle start strobe. The sequencer then clocks 11 slots, starting at slot 0 and ending at slot 10. It pulls the select line low only in the target slot.

In a program cycle, the lines come to rest high. After a setup interval the program-voltage enable is raised for a fixed pulse. In a read cycle, no pulse is raised. The verify input is sampled once the lines have rested high for the same setup interval, and the sampled level is latched as the stored bit. Each cycle touches exactly one bit, so programming several bits takes one full cycle per bit. The serial half-period, the setup interval and the pulse length are counts of system clocks set by parameters. At the defaults and a 100 MHz clock, the setup is 4 µs and the pulse is 10 ms.

Top module: `fbp_seq`

## Requirements
- R1: Out of reset and whenever busy_o is low, sel_o and sclk_o are high, pv_en_o is low, and done_o and err_o are low.
- R2: An accepted command produces exactly 11 serial slots. Each slot holds sclk_o low for HALF_CYC clocks and then high for HALF_CYC clocks. The slot's select value is stable at the rising sclk_o edge.
- R3: At the rising edge of slot k (k = 0 first, 10 last), sel_o is 0 when k equals idx_i and 1 otherwise. The select is active low and marks a single bit.
- R4: In a program command (op_rd_i = 0), pv_en_o rises no sooner than SETUP_CYC clocks after the last rising sclk_o edge. While pv_en_o is high, sel_o and sclk_o are high.
- R5: In a program command, pv_en_o stays high for exactly PULSE_CYC clocks. done_o pulses in the clock after it falls.
- R6: In a read command (op_rd_i = 1), pv_en_o never rises. After the slots, verify_i is sampled with sel_o and sclk_o high. rdata_o then equals that level (low = 0, high = 1) when done_o pulses.
- R7: busy_o is high from the clock after an accepted start until done_o pulses. done_o lasts one clock. rdata_o changes only on a read completion and keeps its value through program commands.
- R8: A start with idx_i above 10 is rejected. err_o pulses for one clock in the next cycle, busy_o stays low and the lines stay idle.
- R9: A start strobe while busy_o is high is ignored. The running command's slot pattern, pulse length and result are unaffected.
- R10: A start in the same clock as done_o is accepted and runs a complete new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe, one clock |
| op_rd_i | input | 1 | 1 = read target bit, 0 = program it |
| idx_i | input | IDXW | Target bit index, valid 0 to 10 |
| verify_i | input | 1 | Digitized verify level from the store |
| sel_o | output | 1 | Select/data line, low marks the target slot |
| sclk_o | output | 1 | Serial clock to the store |
| pv_en_o | output | 1 | Program-voltage enable |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | One-clock pulse for a rejected index |
| rdata_o | output | 1 | Bit value latched by the last read |

## Verification
Two events can fall in the same clock: a command completing, with done_o pulsing and rdata_o updating, and a new start strobe. The bench waits for done_o at a falling edge and raises start in that same clock. It judges the second command on its full slot pattern and pulse length, and checks that the first result is still on rdata_o. A second pairing is a start strobe that lands inside a running program cycle. It is judged by the running command's pattern, its exact pulse width and an unchanged rdata_o.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_SETUP = 2'd2,
    ST_PULSE = 2'd3
  } fbp_state_e;
endpackage

// File: rtl/fbp_shifter.sv
module fbp_shifter #(
  parameter int NBITS    = 11,
  parameter int HALF_CYC = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NBITS-1:0] pat_i,
  output logic             sel_o,
  output logic             sclk_o,
  output logic             fin_o
);
  localparam int SW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int HW = $clog2(HALF_CYC) + 1;

  logic             active_q, phase_q, fin_q;
  logic [NBITS-1:0] pat_q;
  logic [SW-1:0]    slot_q;
  logic [HW-1:0]    hcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      fin_q    <= 1'b0;
      pat_q    <= '1;
      slot_q   <= '0;
      hcnt_q   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        phase_q  <= 1'b0;
        pat_q    <= pat_i;
        slot_q   <= '0;
        hcnt_q   <= HW'(HALF_CYC - 1);
      end else if (active_q) begin
        if (hcnt_q != '0) begin
          hcnt_q <= hcnt_q - 1'b1;
        end else if (!phase_q) begin
          phase_q <= 1'b1;                 // rising edge: store captures slot
          hcnt_q  <= HW'(HALF_CYC - 1);
        end else if (slot_q == SW'(NBITS - 1)) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          slot_q  <= slot_q + 1'b1;
          pat_q   <= {1'b1, pat_q[NBITS-1:1]};
          hcnt_q  <= HW'(HALF_CYC - 1);
        end
      end
    end
  end

  assign sel_o  = active_q ? pat_q[0] : 1'b1;
  assign sclk_o = active_q ? phase_q  : 1'b1;
  assign fin_o  = fin_q;
endmodule

// File: rtl/fbp_timer.sv
module fbp_timer #(
  parameter int W = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
  import fbp_pkg::*;
#(
  parameter int NBITS     = 11,
  parameter int HALF_CYC  = 50,
  parameter int SETUP_CYC = 400,
  parameter int PULSE_CYC = 1_000_000,
  parameter int IDXW      = $clog2(NBITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            op_rd_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic            verify_i,
  output logic            sel_o,
  output logic            sclk_o,
  output logic            pv_en_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            rdata_o
);
  localparam int TMAX = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  fbp_state_e       st_q, st_d;
  logic             op_q, done_q, err_q, rdata_q;
  logic             idx_ok, accept;
  logic             sh_start, sh_fin;
  logic             t_load, t_zero, smp, fin_cmd;
  logic [TW-1:0]    t_val;
  logic [NBITS-1:0] sel_pat;

  for (genvar k = 0; k < NBITS; k++) begin : g_pat
    assign sel_pat[k] = (idx_i != IDXW'(k));
  end

  assign idx_ok = (int'(idx_i) < NBITS);
  assign accept = (st_q == ST_IDLE) && start_i && idx_ok;

  fbp_shifter #(.NBITS(NBITS), .HALF_CYC(HALF_CYC)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sh_start),
    .pat_i  (sel_pat),
    .sel_o  (sel_o),
    .sclk_o (sclk_o),
    .fin_o  (sh_fin)
  );

  fbp_timer #(.W(TW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (t_load),
    .val_i  (t_val),
    .zero_o (t_zero)
  );

  always_comb begin
    st_d     = st_q;
    sh_start = 1'b0;
    t_load   = 1'b0;
    t_val    = '0;
    smp      = 1'b0;
    fin_cmd  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        sh_start = 1'b1;
        st_d     = ST_SHIFT;
      end
      ST_SHIFT: if (sh_fin) begin
        t_load = 1'b1;
        t_val  = TW'(SETUP_CYC - 1);
        st_d   = ST_SETUP;
      end
      ST_SETUP: if (t_zero) begin
        if (op_q) begin
          smp     = 1'b1;             // lines rest high here
          fin_cmd = 1'b1;
          st_d    = ST_IDLE;
        end else begin
          t_load = 1'b1;
          t_val  = TW'(PULSE_CYC - 1);
          st_d   = ST_PULSE;
        end
      end
      ST_PULSE: if (t_zero) begin
        fin_cmd = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin_cmd;
      err_q  <= (st_q == ST_IDLE) && start_i && !idx_ok;
      if (accept) op_q    <= op_rd_i;
      if (smp)    rdata_q <= verify_i;
    end
  end

  assign pv_en_o = (st_q == ST_PULSE);
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/fbp_seq_chk.sv
module fbp_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sel_o,
  input logic sclk_o,
  input logic pv_en_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic rdata_o
);
  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sel_o && sclk_o && !pv_en_o));

  assert_pv_lines_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pv_en_o |-> (sel_o && sclk_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_rdata_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(rdata_o));

  assert_err_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(start_i) && !busy_o));

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind fbp_seq fbp_seq_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .sel_o  (sel_o),
  .sclk_o (sclk_o),
  .pv_en_o(pv_en_o),
  .busy_o (busy_o),
  .done_o (done_o),
  .err_o  (err_o),
  .rdata_o(rdata_o)
);

// File: tb/sim_fbp_seq.sv
module sim_fbp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 2;
  localparam int SETUP = 5;
  localparam int PULSE = 20;
  localparam int NB    = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_rd = 1'b0, verify = 1'b0;
  logic [3:0] idx = '0;
  logic sel, sclk, pv_en, busy, done, err, rdata;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbp_seq #(.NBITS(NB), .HALF_CYC(HALF), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_rd_i(op_rd), .idx_i(idx),
    .verify_i(verify), .sel_o(sel), .sclk_o(sclk), .pv_en_o(pv_en),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives start there and samples each later falling edge.
  task automatic run_cmd(input logic rd, input int ix, input logic vlev, input bit poke,
                         output logic [10:0] pat, output int rises, output int pvcnt,
                         output int gap, output bit pv_bad, output bit busy_bad);
    int cyc = 0, last_rise = 0, first_pv = -1;
    logic prev_sclk = 1'b1;
    pat = '1; rises = 0; pvcnt = 0; pv_bad = 0; busy_bad = 0;
    start = 1'b1; op_rd = rd; idx = 4'(ix); verify = vlev;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (poke && cyc == 4) begin start = 1'b1; op_rd = 1'b1; idx = 4'd3; end
      if (poke && cyc == 5) start = 1'b0;
      if (done) break;
      if (!busy) busy_bad = 1;
      if (sclk && !prev_sclk) begin
        if (rises < 11) pat[rises] = sel;
        rises++;
        last_rise = cyc;
      end
      prev_sclk = sclk;
      if (pv_en) begin
        if (first_pv < 0) first_pv = cyc;
        pvcnt++;
        if (!(sel && sclk)) pv_bad = 1;
      end
      if (cyc > 5000) break;
    end
    gap = (first_pv < 0) ? -1 : first_pv - last_rise;
  endtask

  function automatic logic [10:0] exp_pat(input int ix);
    logic [10:0] p = '1;
    p[ix] = 1'b0;
    return p;
  endfunction

  task automatic t_program(input int ix);
    logic [10:0] pat; int rises, pvcnt, gap; bit pvb, bb; logic r0;
    r0 = rdata;
    run_cmd(1'b0, ix, ~r0, 0, pat, rises, pvcnt, gap, pvb, bb);
    chk(rises == NB, "R2 slot count", rises, NB);
    chk(pat == exp_pat(ix), "R3 select pattern", int'(pat), int'(exp_pat(ix)));
    chk(gap >= SETUP, "R4 setup gap", gap, SETUP);
    chk(!pvb, "R4 lines high during pulse", int'(pvb), 0);
    chk(pvcnt == PULSE, "R5 pulse width", pvcnt, PULSE);
    chk(!bb, "R7 busy held", int'(bb), 0);
    chk(rdata == r0, "R7 rdata kept over program", int'(rdata), int'(r0));
  endtask

  task automatic t_read(input int ix, input logic vlev);
    logic [10:0] pat; int rises, pvcnt, gap; bit pvb, bb;
    run_cmd(1'b1, ix, vlev, 0, pat, rises, pvcnt, gap, pvb, bb);
    chk(pat == exp_pat(ix), "R3 read pattern", int'(pat), int'(exp_pat(ix)));
    chk(pvcnt == 0, "R6 no pulse on read", pvcnt, 0);
    chk(rdata == vlev, "R6 read value", int'(rdata), int'(vlev));
    @(negedge clk);
    chk(!done, "R7 done one clock", int'(done), 0);
    chk(rdata == vlev, "R6 value held", int'(rdata), int'(vlev));
  endtask

  task automatic t_bad_index();
    start = 1'b1; op_rd = 1'b0; idx = 4'd12;
    @(negedge clk); start = 1'b0;
    chk(err == 1'b1, "R8 err pulse", int'(err), 1);
    chk(!busy && sel && sclk && !pv_en, "R8 lines idle", int'({busy, sel, sclk, pv_en}), 6);
    @(negedge clk);
    chk(err == 1'b0, "R8 err one clock", int'(err), 0);
    chk(!busy, "R8 no busy", int'(busy), 0);
  endtask

  task automatic t_busy_ignore();
    logic [10:0] pat; int rises, pvcnt, gap; bit pvb, bb; logic r0;
    r0 = rdata;
    run_cmd(1'b0, 7, ~r0, 1, pat, rises, pvcnt, gap, pvb, bb);
    chk(pat == exp_pat(7), "R9 pattern kept", int'(pat), int'(exp_pat(7)));
    chk(pvcnt == PULSE, "R9 pulse kept", pvcnt, PULSE);
    chk(rdata == r0, "R9 rdata kept", int'(rdata), int'(r0));
    @(negedge clk);
    chk(!busy, "R9 no second command", int'(busy), 0);
  endtask

  task automatic t_back_to_back();
    logic [10:0] pat; int rises, pvcnt, gap; bit pvb, bb;
    run_cmd(1'b1, 2, 1'b1, 0, pat, rises, pvcnt, gap, pvb, bb);
    chk(rdata == 1'b1, "R10 first read", int'(rdata), 1);
    // done is high now; start issued in the same clock
    run_cmd(1'b0, 9, 1'b0, 0, pat, rises, pvcnt, gap, pvb, bb);
    chk(pat == exp_pat(9), "R10 second pattern", int'(pat), int'(exp_pat(9)));
    chk(rises == NB, "R10 second slot count", rises, NB);
    chk(pvcnt == PULSE, "R10 second pulse", pvcnt, PULSE);
    chk(rdata == 1'b1, "R10 rdata after program", int'(rdata), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sel && sclk && !pv_en, "R1 reset lines", int'({sel, sclk, pv_en}), 6);
    chk(!busy && !done && !err, "R1 reset status", int'({busy, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel && sclk && !busy, "R1 idle after reset", int'({sel, sclk, busy}), 6);
    t_program(0);
    t_program(10);
    t_program(4);
    t_read(5, 1'b1);
    t_read(5, 1'b0);
    t_read(0, 1'b1);
    t_bad_index();
    t_busy_ignore();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule